// File: doc/BRIEF.md
# PROM Image Checksum Validator

This block validates a configuration image as it streams out of a nonvolatile memory reader. The image arrives as 16-bit words on a valid/ready interface, one word per accepted beat. A one-cycle start pulse opens each image, and a last flag marks its final word. An 8-bit CRC is folded over the image one byte per clock. The result is inverted and compared with the checksum byte stored in the final word. The layout revision held in that same word is then qualified against two permitted values.

When the image ends, the block raises a one-cycle done pulse. It presents a checksum verdict, a revision verdict, a length-error flag and the extracted revision. These results hold until the next start pulse. The expected image length is a parameter, and an image that is shorter or longer than that length is reported as a length error. Fetching the words, decoding the image contents and choosing a substitute image are left to neighbouring logic.

Top module: `prom_img_chk`

## Requirements
- R1: The CRC uses the generator x^8+x^7+x^6+x^4+x^2+1 in bit-reflected form (constant 0xAB), shifting LSB first. It starts from 0xFF on each start pulse. For each word except the final one, it folds in bits [7:0] first and then bits [15:8].
- R2: For the final word only bits [7:0] enter the CRC. The register is then XORed with 0xFF, and crc_ok_o is 1 exactly when that value equals bits [15:8] of the final word and no length error occurred.
- R3: rev_o carries bits [7:0] of the final word.
- R4: rev_ok_o is 1 only when crc_ok_o is 1 and rev_o equals REV_A (default 8) or REV_B (default 9). Any other revision gives rev_ok_o = 0 even with a matching checksum.
- R5: The image is final at the word carrying word_last_i or at word number IMG_WORDS, whichever comes first. len_err_o is 1 unless the final word is word number IMG_WORDS and carries word_last_i. A length error forces crc_ok_o and rev_ok_o to 0.
- R6: done_o is high for exactly one cycle, two clock edges after the edge that accepts the final word.
- R7: A start pulse clears done_o, crc_ok_o, rev_ok_o, len_err_o and rev_o to 0. Between start pulses, the results change only at the edge that raises done_o.
- R8: word_ready_o is high only while the block awaits a word. After any accepted word it stays low for at least one cycle. Words offered before a start pulse, or after an image has ended, are ignored and leave the outputs unchanged.
- R9: A start pulse in the middle of an image abandons it. The next image is checked from a fresh 0xFF state and word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that opens an image |
| word_valid_i | input | 1 | A word is offered |
| word_i | input | 16 | Image word |
| word_last_i | input | 1 | Offered word is the final one |
| word_ready_o | output | 1 | Block accepts a word this cycle |
| done_o | output | 1 | One-cycle pulse: results are updated |
| crc_ok_o | output | 1 | Computed checksum matches the stored one |
| rev_ok_o | output | 1 | Checksum matches and revision is allowed |
| len_err_o | output | 1 | Image length differs from IMG_WORDS |
| rev_o | output | 8 | Revision byte of the final word |

## Verification
Well-formed images are built with random payloads and revisions 8 and 9 to confirm that both accepted values pass. Revisions 7 and 10 carry correct checksums, which separates the revision check from the checksum check. Single-bit flips in the stored checksum byte, and in the high byte of a middle word, show that every covered byte takes part and that the checksum byte itself is excluded. Early and missing last flags exercise the length check. Offers made while idle, and a restart partway through an image, show that stale state is discarded. Random valid gaps vary the spacing between accepted words.

// File: rtl/prom_chk_pkg.sv
package prom_chk_pkg;
  localparam logic [7:0] CRC_POLY_REFL = 8'hAB;
  localparam logic [7:0] CRC_SEED      = 8'hFF;
  localparam logic [7:0] CRC_XOR_OUT   = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_LO,
    ST_HI,
    ST_FIN
  } seq_st_e;
endpackage

// File: rtl/prom_chk_crc.sv
module prom_chk_crc #(
  parameter logic [7:0] POLY = prom_chk_pkg::CRC_POLY_REFL,
  parameter logic [7:0] SEED = prom_chk_pkg::CRC_SEED,
  parameter int         BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            init_i,
  input  logic            en_i,
  input  logic [BITS-1:0] byte_i,
  output logic [BITS-1:0] crc_o
);
  logic [BITS-1:0] crc_q;
  logic [BITS-1:0] stage [BITS+1];

  assign stage[0] = crc_q ^ byte_i;

  // one reflected shift per bit, LSB first
  for (genvar b = 0; b < BITS; b++) begin : g_bit
    assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ POLY) : (stage[b] >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= SEED;
    else if (init_i)  crc_q <= SEED;
    else if (en_i)    crc_q <= stage[BITS];
  end

  assign crc_o = crc_q;

  // R1
  crc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !en_i) |=> $stable(crc_o));

  // R1
  crc_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (crc_o == SEED));
endmodule

// File: rtl/prom_chk_seq.sv
module prom_chk_seq
  import prom_chk_pkg::*;
#(
  parameter int IMG_WORDS = 64,
  parameter int WORD_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              ready_o,
  output logic              crc_init_o,
  output logic              crc_en_o,
  output logic [7:0]        crc_byte_o,
  output logic              fin_o,
  output logic [WORD_W-1:0] final_word_o,
  output logic              len_ok_o
);
  localparam int              CNT_W    = $clog2(IMG_WORDS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(IMG_WORDS - 1);

  seq_st_e           state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] hold_q;
  logic              final_q;
  logic              len_ok_q;
  logic              accept;

  assign ready_o = (state_q == ST_RECV);
  assign accept  = valid_i && ready_o && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      hold_q   <= '0;
      final_q  <= 1'b0;
      len_ok_q <= 1'b0;
    end else if (start_i) begin
      state_q  <= ST_RECV;
      cnt_q    <= '0;
      final_q  <= 1'b0;
      len_ok_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RECV: if (accept) begin
          hold_q   <= data_i;
          final_q  <= last_i || (cnt_q == LAST_IDX);
          len_ok_q <= last_i && (cnt_q == LAST_IDX);
          state_q  <= ST_LO;
        end
        ST_LO:   state_q <= final_q ? ST_FIN : ST_HI;
        ST_HI: begin
          cnt_q   <= cnt_q + 1'b1;
          state_q <= ST_RECV;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign crc_init_o   = start_i;
  assign crc_en_o     = !start_i && ((state_q == ST_LO) || (state_q == ST_HI));
  assign crc_byte_o   = (state_q == ST_HI) ? hold_q[15:8] : hold_q[7:0];
  assign fin_o        = !start_i && (state_q == ST_FIN);
  assign final_word_o = hold_q;
  assign len_ok_o     = len_ok_q;

  // R8
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ready_o);

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_IDX);

  // R9
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (ready_o && !crc_en_o));
endmodule

// File: rtl/prom_chk_judge.sv
module prom_chk_judge
  import prom_chk_pkg::*;
#(
  parameter logic [7:0] REV_A  = 8'd8,
  parameter logic [7:0] REV_B  = 8'd9,
  parameter int         WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fin_i,
  input  logic [7:0]        crc_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              len_ok_i,
  output logic              done_o,
  output logic              crc_ok_o,
  output logic              rev_ok_o,
  output logic              len_err_o,
  output logic [7:0]        rev_o
);
  logic [7:0] sum;
  logic       sum_match;
  logic       rev_allowed;

  assign sum         = crc_i ^ CRC_XOR_OUT;
  assign sum_match   = len_ok_i && (sum == word_i[15:8]);
  assign rev_allowed = (word_i[7:0] == REV_A) || (word_i[7:0] == REV_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      crc_ok_o  <= 1'b0;
      rev_ok_o  <= 1'b0;
      len_err_o <= 1'b0;
      rev_o     <= '0;
    end else if (start_i) begin
      done_o    <= 1'b0;
      crc_ok_o  <= 1'b0;
      rev_ok_o  <= 1'b0;
      len_err_o <= 1'b0;
      rev_o     <= '0;
    end else if (fin_i) begin
      done_o    <= 1'b1;
      crc_ok_o  <= sum_match;
      rev_ok_o  <= sum_match && rev_allowed;
      len_err_o <= !len_ok_i;
      rev_o     <= word_i[7:0];
    end else begin
      done_o    <= 1'b0;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  rev_needs_crc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rev_ok_o |-> crc_ok_o);

  // R5
  len_blocks_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |-> (!crc_ok_o && !rev_ok_o));

  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !fin_i) |=> $stable({crc_ok_o, rev_ok_o, len_err_o, rev_o}));

  // R7
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && !crc_ok_o && !rev_ok_o && !len_err_o && rev_o == 8'd0));
endmodule

// File: rtl/prom_img_chk.sv
module prom_img_chk #(
  parameter int         IMG_WORDS = 64,
  parameter logic [7:0] REV_A     = 8'd8,
  parameter logic [7:0] REV_B     = 8'd9
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        word_valid_i,
  input  logic [15:0] word_i,
  input  logic        word_last_i,
  output logic        word_ready_o,
  output logic        done_o,
  output logic        crc_ok_o,
  output logic        rev_ok_o,
  output logic        len_err_o,
  output logic [7:0]  rev_o
);
  localparam int WORD_W = 16;

  logic              crc_init;
  logic              crc_en;
  logic [7:0]        crc_byte;
  logic [7:0]        crc_val;
  logic              fin;
  logic [WORD_W-1:0] final_word;
  logic              len_ok;

  prom_chk_seq #(.IMG_WORDS(IMG_WORDS), .WORD_W(WORD_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .valid_i      (word_valid_i),
    .last_i       (word_last_i),
    .data_i       (word_i),
    .ready_o      (word_ready_o),
    .crc_init_o   (crc_init),
    .crc_en_o     (crc_en),
    .crc_byte_o   (crc_byte),
    .fin_o        (fin),
    .final_word_o (final_word),
    .len_ok_o     (len_ok)
  );

  prom_chk_crc u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (crc_init),
    .en_i   (crc_en),
    .byte_i (crc_byte),
    .crc_o  (crc_val)
  );

  prom_chk_judge #(.REV_A(REV_A), .REV_B(REV_B), .WORD_W(WORD_W)) u_judge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .fin_i     (fin),
    .crc_i     (crc_val),
    .word_i    (final_word),
    .len_ok_i  (len_ok),
    .done_o    (done_o),
    .crc_ok_o  (crc_ok_o),
    .rev_ok_o  (rev_ok_o),
    .len_err_o (len_err_o),
    .rev_o     (rev_o)
  );

  // R8
  idle_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !word_ready_o);
endmodule

// File: tb/prom_img_chk_test.sv
module prom_img_chk_test;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] data = '0;
  logic        last = 1'b0;
  logic        ready, done, crc_ok, rev_ok, len_err;
  logic [7:0]  rev;

  logic [15:0] img [N];
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  prom_img_chk #(.IMG_WORDS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .word_valid_i(valid), .word_i(data), .word_last_i(last),
    .word_ready_o(ready), .done_o(done), .crc_ok_o(crc_ok),
    .rev_ok_o(rev_ok), .len_err_o(len_err), .rev_o(rev)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c ^ b;
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 8'hAB) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] model_sum(input int n);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < n - 1; i++) begin
      c = step(c, img[i][7:0]);
      c = step(c, img[i][15:8]);
    end
    c = step(c, img[n-1][7:0]);
    return c ^ 8'hFF;
  endfunction

  task automatic build(input logic [7:0] r, input bit good);
    for (int i = 0; i < N; i++) img[i] = 16'($urandom);
    img[N-1][7:0]  = r;
    img[N-1][15:8] = model_sum(N);
    if (!good) img[N-1][15:8] ^= 8'(1 << ($urandom % 8));
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // sends words 0..n-1 with random gaps; last flag on word n-1 if lf
  task automatic send(input int n, input bit lf);
    int i = 0;
    while (i < n) begin
      @(negedge clk);
      if (($urandom % 4) == 0) begin
        valid = 1'b0;
      end else begin
        valid = 1'b1;
        data  = img[i];
        last  = lf && (i == n - 1);
        if (ready) i++;
      end
    end
  endtask

  task automatic finish_img(input bit e_crc, input bit e_rev, input bit e_len,
                            input logic [7:0] e_rv, input string tag);
    @(negedge clk); valid = 1'b0; last = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R6", {tag, " early done"}, done, 0);
    @(negedge clk);
    chk(done == 1'b1, "R6", {tag, " done"}, done, 1);
    chk(crc_ok == e_crc, "R2", {tag, " crc_ok"}, crc_ok, e_crc);
    chk(rev_ok == e_rev, "R4", {tag, " rev_ok"}, rev_ok, e_rev);
    chk(len_err == e_len, "R5", {tag, " len_err"}, len_err, e_len);
    chk(rev == e_rv, "R3", {tag, " rev"}, rev, e_rv);
    @(negedge clk);
    chk(done == 1'b0, "R6", {tag, " done width"}, done, 0);
  endtask

  task automatic run_full(input logic [7:0] r, input bit good, input string tag);
    build(r, good);
    pulse_start();
    send(N, 1'b1);
    finish_img(good, good && (r == 8 || r == 9), 1'b0, r, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    // reset state
    chk(ready == 0 && done == 0 && crc_ok == 0 && rev_ok == 0 && len_err == 0 && rev == 0,
        "R7", "reset outputs", {ready, done, crc_ok, rev_ok, len_err}, 0);
    rst_n = 1'b1;

    // R1 model self-check: byte 0x01 from 0 gives 0xF7
    chk(step(8'h00, 8'h01) == 8'hF7, "R1", "model table entry", step(8'h00, 8'h01), 8'hF7);

    // R8 offers while idle are ignored
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); valid = 1'b1; data = 16'hBEEF; last = 1'b1;
      chk(ready == 1'b0, "R8", "ready while idle", ready, 0);
    end
    @(negedge clk); valid = 1'b0; last = 1'b0;
    chk(done == 0 && crc_ok == 0, "R8", "idle offer effect", {done, crc_ok}, 0);

    run_full(8'd8, 1'b1, "rev8");
    run_full(8'd9, 1'b1, "rev9");
    run_full(8'd7, 1'b1, "rev7");
    run_full(8'd10, 1'b1, "rev10");
    run_full(8'd8, 1'b0, "badsum");

    // R1 high byte of a middle word is covered
    build(8'd9, 1'b1);
    img[5][15] = ~img[5][15];
    pulse_start(); send(N, 1'b1);
    finish_img(1'b0, 1'b0, 1'b0, 8'd9, "R1 hibyte flip");

    // R1 all-zero payload
    for (int i = 0; i < N; i++) img[i] = '0;
    img[N-1][7:0] = 8'd8; img[N-1][15:8] = model_sum(N);
    pulse_start(); send(N, 1'b1);
    finish_img(1'b1, 1'b1, 1'b0, 8'd8, "R1 zeros");

    // R7 hold, R8 ignored offers after the image ended
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); valid = 1'b1; data = 16'h1234; last = 1'b1;
      chk(ready == 0 && crc_ok == 1 && rev_ok == 1 && rev == 8'd8 && done == 0,
          "R7", "held result", {ready, crc_ok, rev_ok, done}, 4'b0110);
    end
    @(negedge clk); valid = 1'b0; last = 1'b0;

    // R7 start clears
    pulse_start();
    chk(crc_ok == 0 && rev_ok == 0 && rev == 0 && len_err == 0 && done == 0,
        "R7", "start clears", {crc_ok, rev_ok, len_err}, 0);

    // R5 short image
    build(8'd8, 1'b1);
    send(10, 1'b1);
    finish_img(1'b0, 1'b0, 1'b1, img[9][7:0], "R5 short");

    // R5 missing last flag
    build(8'd8, 1'b1);
    pulse_start(); send(N, 1'b0);
    finish_img(1'b0, 1'b0, 1'b1, 8'd8, "R5 nolast");

    // R9 restart mid-image
    build(8'd8, 1'b1);
    for (int i = 0; i < N; i++) img[i] = ~img[i];
    pulse_start(); send(20, 1'b0);
    @(negedge clk); valid = 1'b0;
    build(8'd9, 1'b1);
    pulse_start(); send(N, 1'b1);
    finish_img(1'b1, 1'b1, 1'b0, 8'd9, "R9 restart");

    // random mix
    for (int t = 0; t < 30; t++) begin
      logic [7:0] r = 8'(7 + ($urandom % 4));
      bit g = ($urandom % 3) != 0;
      run_full(r, g, "rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule